// File: doc/BRIEF.md
# Programmable Satellite Spreading-Code Generator

This block produces the chip stream for one receiver tracking channel. It covers two code families. The first is the 1023-chip Gold codes built from two 10-stage shift registers, G1 and G2. The second is the 511-chip maximal-length code of a 9-stage register. The control word chooses the family. For the Gold codes it also chooses how the code is picked. In tap mode, two compact 4-bit fields each name one G2 output stage. In preset mode, a 10-bit value is written into G2 after the first chip. Preset mode can reach codes that no pair of taps can produce. For the 9-stage code, one control bit chooses between the operational feedback set and a test feedback set.

A chip-rate enable advances the registers. A restart strobe starts a new epoch, and a channel gate freezes all state while it is closed. The block drives an end-of-epoch pulse on the last chip of each epoch. It raises an invalid-accumulation flag when the code selection changes while the channel is running, so the accumulation that follows can be discarded. A mode or family switch is meant to be made with the gate closed, and the flag stays low in that case.

Control word layout (`ctrl_word_i`):
- bits 3:0 hold tap field A.
- bits 7:4 hold tap field B.
- bit 8 is the mode bit: 1 selects preset mode.
- bit 9 is reserved.
- bit 10 is the family bit: 1 selects the 9-stage code.
- In the 9-stage family, bit 0 is the feedback-set bit.

Top module: `sat_code_gen`

## Requirements
- R1: After reset, with the gate closed and tap mode selected, `chip_o` is 1, and `epoch_end_o` and `acc_invalid_o` are 0.
- R2: A tap field value 0b0nnn selects G2 stage nnn+1 (stages 1 to 8). A value 0b1xx0 selects stage 9 and 0b1xx1 selects stage 10. The two middle bits have no effect on the chips.
- R3: In tap mode, `chip_o` = G1 stage 10 XOR the two selected G2 stages. G1 feeds back stages 3 and 10, and G2 feeds back stages 2, 3, 6, 8, 9 and 10. Both registers are all ones at chip 0, and stage 1 takes the feedback on each shift. With fields 0001/0101 (stages 2 and 6), the first ten chips are 1100100000.
- R4: In preset mode, `chip_o` = G1 stage 10 XOR G2 stage 10. Chip 0 comes from the all-ones registers, so it is 0. On the advance to chip 1, G2 is loaded with `g2_preset_i`, where bit k gives stage k+1, instead of shifting.
- R5: With the family bit set, `chip_o` is stage 7 of a 9-stage register that is all ones at chip 0. Its feedback is stages 5 and 9 when bit 0 is 0, and stages 3, 5, 6 and 9 when bit 0 is 1.
- R6: An epoch is 1023 chips for the Gold codes and 511 chips for the 9-stage code. `epoch_end_o` is high only on the last chip. The next chip enable returns to chip 0 with all registers at all ones.
- R7: State advances only when `chip_en_i` and `gate_open_i` are both high. While the gate is closed, all state holds, including the flag, and a restart strobe has no effect.
- R8: A restart strobe with the gate open returns the channel to chip 0 on the next edge. It has priority over the chip enable.
- R9: A change of the active selection fields while the gate is open sets `acc_invalid_o` from the next cycle. The active fields are the tap fields in tap mode, the preset value in preset mode, and bit 0 in the 9-stage family. The flag stays set through the last chip of the epoch in progress. The wrap or a restart clears it.
- R10: A change of the mode bit or the family bit while the gate is open also sets the flag. The same change made while the gate is closed does not set it.
- R11: A change of fields that the current selection does not use leaves the flag low. Examples are the preset value in tap mode and the tap bits 7:4 in the 9-stage family.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word_i | input | 11 | Code selection word (layout above) |
| g2_preset_i | input | 10 | G2 state loaded for chip 1 in preset mode |
| chip_en_i | input | 1 | Chip-rate advance enable |
| epoch_start_i | input | 1 | Restart the epoch at chip 0 |
| gate_open_i | input | 1 | Channel clock gate; low freezes all state |
| chip_o | output | 1 | Current code chip |
| epoch_end_o | output | 1 | High during the last chip of the epoch |
| acc_invalid_o | output | 1 | The accumulation in progress is invalid |

## Verification
The hardest condition to reach is the flag window. A selection change in the middle of an epoch has to keep the flag high through the very last chip and then drop it exactly at the wrap, and the mode and family switches must be told apart by the state of the gate. The stimulus keeps the chip enable high and applies field edits between chips at known chip counts. It then steps a reference model in lockstep up to chip 1022, which shows both the held flag and its release on the wrap. Closed-gate switches are made by closing the gate for a single cycle around the edit, so the reopening edge advances the channel without a detected change.

// File: rtl/scg_pkg.sv
`timescale 1ns/1ps
package scg_pkg;
    localparam int G_W      = 10;
    localparam int R_W      = 9;
    localparam int TAP_W    = 8;
    localparam int CW_W     = 11;
    localparam int CW_TYPE  = 0;
    localparam int CW_MODE  = 8;
    localparam int CW_FAM   = 10;
    localparam int R_OUT    = 6;
    localparam logic [G_W-1:0] G1_FB     = 10'h204;
    localparam logic [G_W-1:0] G2_FB     = 10'h3A6;
    localparam logic [R_W-1:0] R_FB_OP   = 9'h110;
    localparam logic [R_W-1:0] R_FB_TEST = 9'h134;

    typedef struct packed {
        logic             fam;
        logic             pmode;
        logic [TAP_W-1:0] taps;
        logic [G_W-1:0]   preset;
    } sel_t;
endpackage

// File: rtl/scg_tap_sel.sv
`timescale 1ns/1ps
module scg_tap_sel
    import scg_pkg::*;
(
    input  logic [3:0]     field_i,
    output logic [G_W-1:0] mask_o
);
    always_comb begin
        mask_o = '0;
        if (field_i[3]) begin
            mask_o[{3'b100, field_i[0]}] = 1'b1;
        end else begin
            mask_o[{1'b0, field_i[2:0]}] = 1'b1;
        end
    end
endmodule

// File: rtl/scg_lfsr.sv
`timescale 1ns/1ps
module scg_lfsr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload_i,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] fb_mask_i,
    output logic [W-1:0] state_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_t;

    lfsr_t lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (reload_i) begin
            lfsr_d.sr = '1;
        end else if (load_i) begin
            lfsr_d.sr = load_val_i;
        end else if (step_i) begin
            lfsr_d.sr = {lfsr_q.sr[W-2:0], ^(lfsr_q.sr & fb_mask_i)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q.sr <= '1;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign state_o = lfsr_q.sr;
endmodule

// File: rtl/scg_ctrl.sv
`timescale 1ns/1ps
module scg_ctrl
    import scg_pkg::*;
#(
    parameter int GPS_LEN = 1023,
    parameter int GLO_LEN = 511,
    parameter int CNT_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic             chip_en_i,
    input  logic             start_i,
    input  logic             fam_i,
    input  logic             pmode_i,
    input  logic [TAP_W-1:0] taps_i,
    input  logic [G_W-1:0]   preset_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             epoch_end_o,
    output logic             reload_o,
    output logic             gold_step_o,
    output logic             mls_step_o,
    output logic             g2_load_o,
    output logic             invalid_o,
    output logic             primed_o
);
    localparam logic [CNT_W-1:0] GPS_LAST = CNT_W'(GPS_LEN - 1);
    localparam logic [CNT_W-1:0] GLO_LAST = CNT_W'(GLO_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        sel_t             sel;
        logic             primed;
        logic             invalid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CNT_W-1:0] last;
    logic at_end, adv, restart, wrap, reload, step, sel_chg, chg;

    always_comb begin
        last    = fam_i ? GLO_LAST : GPS_LAST;
        at_end  = (ctl_q.cnt >= last);
        adv     = gate_i & chip_en_i;
        restart = gate_i & start_i;
        wrap    = adv & at_end & ~restart;
        reload  = restart | wrap;
        step    = adv & ~reload;

        sel_chg = (fam_i != ctl_q.sel.fam) | (pmode_i != ctl_q.sel.pmode);
        if (fam_i) begin
            sel_chg = sel_chg | (taps_i[CW_TYPE] != ctl_q.sel.taps[CW_TYPE]);
        end else if (pmode_i) begin
            sel_chg = sel_chg | (preset_i != ctl_q.sel.preset);
        end else begin
            sel_chg = sel_chg | (taps_i != ctl_q.sel.taps);
        end
        chg = ctl_q.primed & gate_i & sel_chg;

        ctl_d            = ctl_q;
        ctl_d.primed     = 1'b1;
        ctl_d.sel.fam    = fam_i;
        ctl_d.sel.pmode  = pmode_i;
        ctl_d.sel.taps   = taps_i;
        ctl_d.sel.preset = preset_i;

        if (reload) begin
            ctl_d.cnt = '0;
        end else if (step) begin
            ctl_d.cnt = ctl_q.cnt + 1'b1;
        end

        if (chg) begin
            ctl_d.invalid = 1'b1;
        end else if (reload) begin
            ctl_d.invalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cnt_o       = ctl_q.cnt;
    assign epoch_end_o = at_end;
    assign reload_o    = reload;
    assign gold_step_o = step & ~fam_i;
    assign mls_step_o  = step & fam_i;
    assign g2_load_o   = step & ~fam_i & pmode_i & (ctl_q.cnt == '0);
    assign invalid_o   = ctl_q.invalid;
    assign primed_o    = ctl_q.primed;
endmodule

// File: rtl/sat_code_gen.sv
`timescale 1ns/1ps
module sat_code_gen
    import scg_pkg::*;
#(
    parameter int GPS_LEN = 1023,
    parameter int GLO_LEN = 511
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW_W-1:0] ctrl_word_i,
    input  logic [G_W-1:0]  g2_preset_i,
    input  logic            chip_en_i,
    input  logic            epoch_start_i,
    input  logic            gate_open_i,
    output logic            chip_o,
    output logic            epoch_end_o,
    output logic            acc_invalid_o
);
    localparam int MAX_LEN = (GPS_LEN > GLO_LEN) ? GPS_LEN : GLO_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN);

    logic [CNT_W-1:0] epoch_cnt;
    logic [G_W-1:0]   g1_st, g2_st;
    logic [R_W-1:0]   glo_st;
    logic [G_W-1:0]   tap_mask [2];
    logic             reload, gold_step, mls_step, g2_load, primed;
    logic             fam, pmode, tap_bits;
    logic             cw_unused;

    assign fam       = ctrl_word_i[CW_FAM];
    assign pmode     = ctrl_word_i[CW_MODE];
    assign cw_unused = ctrl_word_i[9];

    scg_ctrl #(
        .GPS_LEN(GPS_LEN),
        .GLO_LEN(GLO_LEN),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_i     (gate_open_i),
        .chip_en_i  (chip_en_i),
        .start_i    (epoch_start_i),
        .fam_i      (fam),
        .pmode_i    (pmode),
        .taps_i     (ctrl_word_i[TAP_W-1:0]),
        .preset_i   (g2_preset_i),
        .cnt_o      (epoch_cnt),
        .epoch_end_o(epoch_end_o),
        .reload_o   (reload),
        .gold_step_o(gold_step),
        .mls_step_o (mls_step),
        .g2_load_o  (g2_load),
        .invalid_o  (acc_invalid_o),
        .primed_o   (primed)
    );

    for (genvar k = 0; k < 2; k++) begin : g_tap
        scg_tap_sel u_sel (
            .field_i(ctrl_word_i[4*k+3 -: 4]),
            .mask_o (tap_mask[k])
        );
    end

    scg_lfsr #(.W(G_W)) u_g1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_i  (reload),
        .load_i    (1'b0),
        .step_i    (gold_step),
        .load_val_i('0),
        .fb_mask_i (G1_FB),
        .state_o   (g1_st)
    );

    scg_lfsr #(.W(G_W)) u_g2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_i  (reload),
        .load_i    (g2_load),
        .step_i    (gold_step),
        .load_val_i(g2_preset_i),
        .fb_mask_i (G2_FB),
        .state_o   (g2_st)
    );

    scg_lfsr #(.W(R_W)) u_mls (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_i  (reload),
        .load_i    (1'b0),
        .step_i    (mls_step),
        .load_val_i('0),
        .fb_mask_i (ctrl_word_i[CW_TYPE] ? R_FB_TEST : R_FB_OP),
        .state_o   (glo_st)
    );

    always_comb begin
        tap_bits = (^(g2_st & tap_mask[0])) ^ (^(g2_st & tap_mask[1]));
        if (fam) begin
            chip_o = glo_st[R_OUT];
        end else if (pmode) begin
            chip_o = g1_st[G_W-1] ^ g2_st[G_W-1];
        end else begin
            chip_o = g1_st[G_W-1] ^ tap_bits;
        end
    end
endmodule

// File: rtl/scg_checker.sv
`timescale 1ns/1ps
module scg_checker
    import scg_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_open_i,
    input logic             chip_en_i,
    input logic             epoch_start_i,
    input logic             fam_sel,
    input logic             mode_sel,
    input logic [TAP_W-1:0] taps,
    input logic [G_W-1:0]   g2_preset_i,
    input logic             epoch_end_o,
    input logic             acc_invalid_o,
    input logic [CNT_W-1:0] epoch_cnt,
    input logic [G_W-1:0]   g1_st,
    input logic [G_W-1:0]   g2_st,
    input logic [R_W-1:0]   glo_st,
    input logic             primed
);
    assert_hold_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open_i |=> ($stable(epoch_cnt) && $stable(g1_st) && $stable(g2_st)
                          && $stable(glo_st) && $stable(acc_invalid_o)));

    assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open_i && chip_en_i && !epoch_start_i && epoch_end_o)
        |=> (epoch_cnt == '0 && (&g1_st) && (&g2_st) && (&glo_st)));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open_i && chip_en_i && !epoch_start_i && !epoch_end_o)
        |=> (epoch_cnt == $past(epoch_cnt) + 1'b1));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open_i && epoch_start_i)
        |=> (epoch_cnt == '0 && (&g1_st) && (&g2_st) && (&glo_st)));

    assert_preset_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open_i && chip_en_i && !epoch_start_i && epoch_cnt == '0
         && mode_sel && !fam_sel && !epoch_end_o)
        |=> (g2_st == $past(g2_preset_i)));

    assert_switch_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open_i && primed && (fam_sel != $past(fam_sel) || mode_sel != $past(mode_sel)))
        |=> acc_invalid_o);

    assert_tap_edit_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open_i && primed && !fam_sel && !mode_sel && !$past(fam_sel)
         && !$past(mode_sel) && taps != $past(taps))
        |=> acc_invalid_o);
endmodule

bind sat_code_gen scg_checker #(.CNT_W(CNT_W)) u_scg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_open_i  (gate_open_i),
    .chip_en_i    (chip_en_i),
    .epoch_start_i(epoch_start_i),
    .fam_sel      (ctrl_word_i[CW_FAM]),
    .mode_sel     (ctrl_word_i[CW_MODE]),
    .taps         (ctrl_word_i[TAP_W-1:0]),
    .g2_preset_i  (g2_preset_i),
    .epoch_end_o  (epoch_end_o),
    .acc_invalid_o(acc_invalid_o),
    .epoch_cnt    (epoch_cnt),
    .g1_st        (g1_st),
    .g2_st        (g2_st),
    .glo_st       (glo_st),
    .primed       (primed)
);

// File: tb/test_sat_code_gen.sv
`timescale 1ns/1ps
module test_sat_code_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ctrl = 11'h015;
    logic [9:0]  preset = '0;
    logic        en = 1'b0, start = 1'b0, gate = 1'b0;
    logic        chip, ep_end, inval;

    always #4 clk = ~clk;

    sat_code_gen i_sat_code_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_word_i  (ctrl),
        .g2_preset_i  (preset),
        .chip_en_i    (en),
        .epoch_start_i(start),
        .gate_open_i  (gate),
        .chip_o       (chip),
        .epoch_end_o  (ep_end),
        .acc_invalid_o(inval)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [9:0] m_g1, m_g2;
    logic [8:0] m_glo;
    int         m_cnt;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_last();
        return ctrl[10] ? 510 : 1022;
    endfunction

    function automatic int tap_of(input logic [3:0] f);
        if (f[3]) return f[0] ? 10 : 9;
        return int'(f[2:0]) + 1;
    endfunction

    function automatic logic m_out();
        if (ctrl[10]) return m_glo[6];
        if (ctrl[8]) return m_g1[9] ^ m_g2[9];
        return m_g1[9] ^ m_g2[tap_of(ctrl[3:0]) - 1] ^ m_g2[tap_of(ctrl[7:4]) - 1];
    endfunction

    task automatic m_restart();
        m_g1 = '1; m_g2 = '1; m_glo = '1; m_cnt = 0;
    endtask

    task automatic m_step();
        logic fb;
        if (m_cnt >= m_last()) begin
            m_restart();
            return;
        end
        if (ctrl[10]) begin
            fb = ctrl[0] ? (m_glo[2] ^ m_glo[4] ^ m_glo[5] ^ m_glo[8]) : (m_glo[4] ^ m_glo[8]);
            m_glo = {m_glo[7:0], fb};
        end else begin
            fb = m_g2[1] ^ m_g2[2] ^ m_g2[5] ^ m_g2[7] ^ m_g2[8] ^ m_g2[9];
            m_g2 = (ctrl[8] && m_cnt == 0) ? preset : {m_g2[8:0], fb};
            m_g1 = {m_g1[8:0], m_g1[2] ^ m_g1[9]};
        end
        m_cnt++;
    endtask

    task automatic set_cfg(input logic [10:0] c, input logic [9:0] p);
        @(negedge clk);
        gate = 1'b0; en = 1'b0; ctrl = c; preset = p;
        @(negedge clk);
    endtask

    task automatic start_epoch();
        start = 1'b1; en = 1'b1; gate = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_restart();
    endtask

    task automatic run_chips(input int n, input string req);
        int bad_chip = 0;
        int bad_end = 0;
        for (int i = 0; i < n; i++) begin
            if (chip !== m_out()) bad_chip++;
            if (ep_end !== (m_cnt == m_last())) bad_end++;
            @(negedge clk);
            m_step();
        end
        check(req, "chip mismatches", bad_chip, 0);
        check("R6", "end-pulse mismatches", bad_end, 0);
    endtask

    task automatic collect(input int n, output logic [255:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            v[i] = chip;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "chip after reset", chip, 1);
        check("R1", "end pulse after reset", ep_end, 0);
        check("R1", "flag after reset", inval, 0);
    endtask

    task automatic t_prn1();
        logic [9:0] got;
        set_cfg(11'h015, 10'h000);
        start_epoch();
        for (int i = 0; i < 10; i++) begin
            got[9-i] = chip;
            @(negedge clk);
            m_step();
        end
        check("R3", "first ten chips stages 2/6", int'(got), int'(10'b1100100000));
        run_chips(1023, "R3");
        check("R6", "flag stays low across wrap", inval, 0);
    endtask

    task automatic t_taps();
        logic [255:0] va, vb;
        set_cfg(11'h00E, 10'h000);
        start_epoch();
        run_chips(200, "R2");
        set_cfg(11'h00E, 10'h000);
        start_epoch();
        collect(200, va);
        set_cfg(11'h008, 10'h000);
        start_epoch();
        collect(200, vb);
        check("R2", "stage 9 middle bits ignored", int'(va == vb), 1);
        set_cfg(11'h08F, 10'h000);
        start_epoch();
        collect(200, va);
        set_cfg(11'h0E9, 10'h000);
        start_epoch();
        collect(200, vb);
        check("R2", "stage 10 middle bits ignored", int'(va == vb), 1);
        start_epoch();
        run_chips(150, "R2");
    endtask

    task automatic t_preset();
        set_cfg(11'h100, 10'h3F6);
        start_epoch();
        check("R4", "chip 0 in preset mode", chip, 0);
        run_chips(300, "R4");
        set_cfg(11'h100, 10'h3EC);
        start_epoch();
        run_chips(1030, "R4");
    endtask

    task automatic t_mls();
        set_cfg(11'h400, 10'h000);
        start_epoch();
        run_chips(520, "R5");
        set_cfg(11'h401, 10'h000);
        start_epoch();
        run_chips(120, "R5");
    endtask

    task automatic t_gate();
        int bad = 0;
        set_cfg(11'h015, 10'h000);
        start_epoch();
        run_chips(20, "R7");
        gate = 1'b0;
        start = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (chip !== m_out() || ep_end !== 1'b0 || inval !== 1'b0) bad++;
        end
        start = 1'b0;
        check("R7", "outputs held while gate closed", bad, 0);
        gate = 1'b1;
        run_chips(20, "R7");
    endtask

    task automatic t_restart();
        set_cfg(11'h015, 10'h000);
        start_epoch();
        run_chips(50, "R8");
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_restart();
        check("R8", "chip 0 after restart", chip, 1);
        run_chips(30, "R8");
    endtask

    task automatic t_invalid();
        int bad = 0;
        set_cfg(11'h015, 10'h000);
        start_epoch();
        run_chips(10, "R9");
        check("R9", "flag low with stable selection", inval, 0);
        preset = 10'h155;
        @(negedge clk); m_step();
        check("R11", "preset edit in tap mode", inval, 0);
        ctrl = 11'h026;
        @(negedge clk); m_step();
        check("R9", "flag after tap edit", inval, 1);
        while (m_cnt != 1022) begin
            if (inval !== 1'b1) bad++;
            @(negedge clk); m_step();
        end
        check("R9", "flag held until last chip", bad, 0);
        check("R9", "flag on last chip", inval, 1);
        @(negedge clk); m_step();
        check("R9", "flag cleared at wrap", inval, 0);
        gate = 1'b0;
        ctrl[8] = 1'b1;
        @(negedge clk);
        gate = 1'b1;
        @(negedge clk); m_step();
        check("R10", "mode switch with gate closed", inval, 0);
        ctrl[10] = 1'b1;
        @(negedge clk); m_step();
        check("R10", "family switch with gate open", inval, 1);
        start_epoch();
        check("R9", "flag cleared by restart", inval, 0);
        ctrl[7:4] = 4'hA;
        @(negedge clk); m_step();
        check("R11", "tap bits edited in 9-stage family", inval, 0);
        ctrl[0] = ~ctrl[0];
        @(negedge clk); m_step();
        check("R9", "feedback-set edit in 9-stage family", inval, 1);
    endtask

    initial begin
        t_reset();
        t_prn1();
        t_taps();
        t_preset();
        t_mls();
        t_gate();
        t_restart();
        t_invalid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1200000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule